// File: doc/BRIEF.md
# Indirect PHY Register Access Port

This block lets host software reach a bank of byte-wide PHY delay registers through one 32-bit access word. Software first loads a 6-bit PHY address and a data byte. It then sets a write strobe or a read strobe in the same word. The block turns each new strobe into a single request/acknowledge transaction toward a PHY-side register file. When that transaction completes, the block raises a completion flag that software can poll.

The host side is a plain register port: a write-enable with a 32-bit write word, and a 32-bit read word that is always valid. The PHY side carries a request held with its address, direction and write byte. The PHY answers with a one-cycle acknowledge and, on reads, a data byte. The delay entries that software normally touches live at PHY addresses 0x00 to 0x08 and 0x0B to 0x0D. The block itself treats all 64 addresses the same way.

Top module: `phy_access_port`

## Requirements
- R1: The access word has these fields. Bits 5:0 hold the PHY address, bits 15:8 the write byte, bits 23:16 the read byte, bit 24 the write strobe, bit 25 the read strobe and bit 26 the acknowledge flag. Address, write byte and both strobes read back as they were last written.
- R2: When the write strobe goes from 0 to 1, the block issues exactly one PHY transaction with `phy_we`=1. That transaction carries the address and write byte that were present when the strobe rose.
- R3: When the read strobe goes from 0 to 1 while the write strobe is clear, the block issues exactly one PHY transaction with `phy_we`=0.
- R4: Keeping a strobe set launches no further transaction. `phy_req`, `phy_addr`, `phy_we` and `phy_wdata` stay stable from the rise of `phy_req` until `phy_ack` is sampled. `phy_req` is low in the cycle after that.
- R5: The acknowledge flag (bit 26) rises at the same clock edge where `phy_ack` is sampled high. It stays set while the strobe that launched the transaction stays set. It clears on the first clock edge after that strobe reads back as 0.
- R6: On a read, `phy_rdata` is captured into bits 23:16 at the same edge where the acknowledge flag rises. Those bits then hold through writes and other accesses until the next read completes.
- R7: If the write strobe is set together with the read strobe, or is already set when the read strobe rises, only the write runs and the read request is dropped.
- R8: Bits 7:6 and 31:27 always read as 0. Host writes to those bits and to bit 26 have no effect.
- R9: After a synchronous active-low reset, the access word reads as 0 and `phy_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host write of the access word |
| host_wr_data | input | 32 | Word written by the host |
| host_rd_data | output | 32 | Current access word as seen by the host |
| phy_req | output | 1 | PHY transaction request, held until acknowledged |
| phy_we | output | 1 | 1 = PHY write, 0 = PHY read |
| phy_addr | output | 6 | PHY register address |
| phy_wdata | output | 8 | Byte to write to the PHY |
| phy_ack | input | 1 | One-cycle completion pulse from the PHY |
| phy_rdata | input | 8 | Read byte from the PHY, valid with `phy_ack` |

## Verification
A table of address/byte/latency vectors drives a full write-then-read sequence through a behavioural 64-byte PHY model. The vectors cover the lowest and highest addresses, all-zero and all-one bytes, and responder latencies from zero to several cycles. Together they separate field-packing errors from capture-timing errors. Directed cases then hold a strobe high to expose repeated launches, and check the acknowledge flag on the exact cycles around a strobe being cleared. They also set both strobes together to confirm that the write wins, and write the unused and acknowledge bits to confirm that nothing changes.

// File: rtl/phy_acc_pkg.sv
// Shared layout of the 32-bit access word and the transaction state type.
// Assumes a 6-bit PHY address and byte-wide PHY data; other field positions
// are fixed because host software decodes them.
package phy_acc_pkg;
    localparam int PHY_ADDR_W = 6;
    localparam int PHY_DATA_W = 8;
    localparam int WORD_W     = 32;
    localparam int ADDR_LSB   = 0;
    localparam int WBYTE_LSB  = 8;
    localparam int RBYTE_LSB  = 16;
    localparam int WR_BIT     = 24;
    localparam int RD_BIT     = 25;
    localparam int ACK_BIT    = 26;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_REQ  = 2'd1,
        XS_DONE = 2'd2
    } xfer_state_t;
endpackage

// File: rtl/acc_ctrl_reg.sv
// Host-writable part of the access word: address, write byte and two strobes.
// Detects 0->1 strobe edges and turns them into launch pulses while the
// sequencer is idle. A write edge, or a write strobe already set, wins over
// a read edge. Assumes the host holds address and byte while a strobe is set.
module acc_ctrl_reg #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              seq_idle,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wbyte_q,
    output logic              wr_stb_q,
    output logic              rd_stb_q,
    output logic              launch_wr,
    output logic              launch_rd
);
    import phy_acc_pkg::*;

    logic wr_prev_q;
    logic rd_prev_q;

    // Capture the host-written fields; all other bits of the word are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wbyte_q  <= '0;
            wr_stb_q <= 1'b0;
            rd_stb_q <= 1'b0;
        end else if (wr_en) begin
            addr_q   <= wr_word[ADDR_LSB +: ADDR_W];
            wbyte_q  <= wr_word[WBYTE_LSB +: DATA_W];
            wr_stb_q <= wr_word[WR_BIT];
            rd_stb_q <= wr_word[RD_BIT];
        end
    end

    // Keep the previous strobe levels so that rising edges can be found.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_prev_q <= 1'b0;
            rd_prev_q <= 1'b0;
        end else begin
            wr_prev_q <= wr_stb_q;
            rd_prev_q <= rd_stb_q;
        end
    end

    // Form launch pulses; the write side has priority over the read side.
    always_comb begin
        launch_wr = seq_idle && wr_stb_q && !wr_prev_q;
        launch_rd = seq_idle && rd_stb_q && !rd_prev_q && !wr_stb_q;
    end
endmodule

// File: rtl/acc_xfer_seq.sv
// Transaction sequencer toward the PHY register file. On a launch it latches
// direction, address and write byte, holds the request until the PHY
// acknowledges, then holds the host-visible acknowledge flag until the
// launching strobe is cleared. Assumes phy_ack is a single-cycle pulse.
module acc_xfer_seq #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_wr,
    input  logic              launch_rd,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wbyte_in,
    input  logic              phy_ack,
    output logic              phy_req,
    output logic              phy_we,
    output logic [ADDR_W-1:0] phy_addr,
    output logic [DATA_W-1:0] phy_wdata,
    output logic              done_flag,
    output logic              seq_idle,
    output logic              cap_en
);
    import phy_acc_pkg::*;

    xfer_state_t       state_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              ack_q;
    logic              own_stb;

    // Select the strobe that launched the current transaction.
    always_comb own_stb = we_q ? wr_stb : rd_stb;

    // Step through idle, request and done states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
            we_q    <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            ack_q   <= 1'b0;
        end else begin
            case (state_q)
                XS_IDLE: begin
                    if (launch_wr || launch_rd) begin
                        state_q <= XS_REQ;
                        we_q    <= launch_wr;
                        addr_q  <= addr_in;
                        data_q  <= wbyte_in;
                    end
                end
                XS_REQ: begin
                    if (phy_ack) begin
                        state_q <= XS_DONE;
                        ack_q   <= 1'b1;
                    end
                end
                XS_DONE: begin
                    if (!own_stb) begin
                        state_q <= XS_IDLE;
                        ack_q   <= 1'b0;
                    end
                end
                default: state_q <= XS_IDLE;
            endcase
        end
    end

    // Drive the PHY request bus and the status outputs.
    always_comb begin
        phy_req   = (state_q == XS_REQ);
        phy_we    = we_q;
        phy_addr  = addr_q;
        phy_wdata = data_q;
        done_flag = ack_q;
        seq_idle  = (state_q == XS_IDLE);
        cap_en    = (state_q == XS_REQ) && phy_ack && !we_q;
    end

    // R4: the request and its payload stay put until acknowledged.
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && !phy_ack) |=> (phy_req && $stable(phy_addr)
                                   && $stable(phy_we) && $stable(phy_wdata)));

    // R4: the request drops right after the acknowledge.
    p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && phy_ack) |=> !phy_req);

    // R5: the flag rises only on a sampled PHY acknowledge.
    p_ack_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(phy_ack));

    // R5: with no strobe left set, the flag is gone one edge later.
    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !wr_stb && !rd_stb) |=> !done_flag);
endmodule

// File: rtl/acc_rbyte_cap.sv
// Read-byte holding register: loads the PHY return byte on a capture pulse
// and otherwise keeps its value. Assumes the capture pulse only comes with
// an acknowledged read.
module acc_rbyte_cap #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] phy_rdata,
    output logic [DATA_W-1:0] rbyte_q
);
    // Hold the most recent PHY read byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      rbyte_q <= '0;
        else if (cap_en) rbyte_q <= phy_rdata;
    end
endmodule

// File: rtl/phy_access_port.sv
// Indirect PHY register access port. Assembles the 32-bit access word from
// the host-written fields, the captured read byte and the acknowledge flag,
// and connects the strobe logic, the transaction sequencer and the read-byte
// register. Assumes a single host writer and one PHY responder.
module phy_access_port #(
    parameter int ADDR_W = phy_acc_pkg::PHY_ADDR_W,
    parameter int DATA_W = phy_acc_pkg::PHY_DATA_W
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr_en,
    input  logic [31:0] host_wr_data,
    output logic [31:0] host_rd_data,
    output logic        phy_req,
    output logic        phy_we,
    output logic [5:0]  phy_addr,
    output logic [7:0]  phy_wdata,
    input  logic        phy_ack,
    input  logic [7:0]  phy_rdata
);
    import phy_acc_pkg::*;

    localparam int LOW_PAD  = WBYTE_LSB - ADDR_W;
    localparam int HIGH_PAD = WORD_W - ACK_BIT - 1;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wbyte_q;
    logic [DATA_W-1:0] rbyte_q;
    logic              wr_stb_q;
    logic              rd_stb_q;
    logic              launch_wr;
    logic              launch_rd;
    logic              seq_idle;
    logic              done_flag;
    logic              cap_en;

    acc_ctrl_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(WORD_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_wr_en),
        .wr_word  (host_wr_data),
        .seq_idle (seq_idle),
        .addr_q   (addr_q),
        .wbyte_q  (wbyte_q),
        .wr_stb_q (wr_stb_q),
        .rd_stb_q (rd_stb_q),
        .launch_wr(launch_wr),
        .launch_rd(launch_rd)
    );

    acc_xfer_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_wr(launch_wr),
        .launch_rd(launch_rd),
        .wr_stb   (wr_stb_q),
        .rd_stb   (rd_stb_q),
        .addr_in  (addr_q),
        .wbyte_in (wbyte_q),
        .phy_ack  (phy_ack),
        .phy_req  (phy_req),
        .phy_we   (phy_we),
        .phy_addr (phy_addr),
        .phy_wdata(phy_wdata),
        .done_flag(done_flag),
        .seq_idle (seq_idle),
        .cap_en   (cap_en)
    );

    acc_rbyte_cap #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .phy_rdata(phy_rdata),
        .rbyte_q  (rbyte_q)
    );

    // Pack the host-visible access word; reserved bits are tied to zero.
    always_comb begin
        host_rd_data = {{HIGH_PAD{1'b0}}, done_flag, rd_stb_q, wr_stb_q,
                        rbyte_q, wbyte_q, {LOW_PAD{1'b0}}, addr_q};
    end

    // R6: the read byte changes only when a PHY read is acknowledged.
    p_rbyte_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(phy_ack && phy_req && !phy_we) |=> $stable(host_rd_data[RBYTE_LSB +: DATA_W]));

    // R7: a request raised while the write strobe was set is a write.
    p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(phy_req) && $past(wr_stb_q)) |-> phy_we);

    // R2: a write request only follows a set write strobe.
    p_wr_needs_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(phy_req) && phy_we) |-> $past(wr_stb_q));
endmodule

// File: tb/phy_access_port_tb.sv
`timescale 1ns/1ps
module phy_access_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [31:0] host_wr_data = '0;
    logic [31:0] host_rd_data;
    logic        phy_req;
    logic        phy_we;
    logic [5:0]  phy_addr;
    logic [7:0]  phy_wdata;
    logic        phy_ack = 1'b0;
    logic [7:0]  phy_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] mem [64];
    int txn_count = 0;
    int resp_delay = 0;
    int resp_cnt = 0;
    logic last_we = 1'b0;

    always #2.5 clk = ~clk;

    phy_access_port u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en),
        .host_wr_data(host_wr_data), .host_rd_data(host_rd_data),
        .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr),
        .phy_wdata(phy_wdata), .phy_ack(phy_ack), .phy_rdata(phy_rdata)
    );

    // Behavioural PHY register file: answers a request after resp_delay cycles.
    always @(posedge clk) begin
        if (!rst_n) begin
            phy_ack  <= 1'b0;
            resp_cnt <= 0;
        end else if (phy_ack) begin
            phy_ack  <= 1'b0;
            resp_cnt <= 0;
        end else if (phy_req) begin
            if (resp_cnt >= resp_delay) begin
                phy_ack   <= 1'b1;
                phy_rdata <= mem[phy_addr];
                if (phy_we) mem[phy_addr] <= phy_wdata;
                last_we   <= phy_we;
                txn_count <= txn_count + 1;
            end else begin
                resp_cnt <= resp_cnt + 1;
            end
        end
    end

    typedef struct packed {
        logic [5:0] addr;
        logic [7:0] data;
        logic [3:0] lat;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{addr: 6'h00, data: 8'h5A, lat: 4'd0},
        '{addr: 6'h3F, data: 8'hFF, lat: 4'd1},
        '{addr: 6'h0D, data: 8'h00, lat: 4'd3},
        '{addr: 6'h08, data: 8'hA5, lat: 4'd5},
        '{addr: 6'h0B, data: 8'h81, lat: 4'd2},
        '{addr: 6'h01, data: 8'h3C, lat: 4'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_put(input logic [31:0] w);
        @(negedge clk);
        host_wr_en   = 1'b1;
        host_wr_data = w;
        @(negedge clk);
        host_wr_en   = 1'b0;
    endtask

    task automatic wait_ack(input string req);
        int n = 0;
        while (!host_rd_data[26] && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(req, {31'd0, host_rd_data[26]}, 32'd1);
    endtask

    function automatic logic [31:0] word(input logic [5:0] a, input logic [7:0] d,
                                         input logic wr, input logic rd);
        return {6'd0, rd, wr, 8'd0, d, 2'd0, a};
    endfunction

    task automatic phy_write(input logic [5:0] a, input logic [7:0] d);
        host_put(word(a, d, 1'b0, 1'b0));
        host_put(word(a, d, 1'b1, 1'b0));
        wait_ack("R5 write ack");
        host_put(word(a, d, 1'b0, 1'b0));
    endtask

    task automatic phy_read(input logic [5:0] a, output logic [7:0] d);
        host_put(word(a, 8'd0, 1'b0, 1'b1));
        wait_ack("R5 read ack");
        d = host_rd_data[23:16];
        host_put(word(a, 8'd0, 1'b0, 1'b0));
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
    end

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rb;
        int base;
        repeat (3) @(negedge clk);
        // R9: reset state.
        chk("R9 word", host_rd_data, 32'd0);
        chk("R9 req", {31'd0, phy_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: write then read back each entry (R2, R3, R6, R4).
        foreach (VECS[i]) begin
            resp_delay = int'(VECS[i].lat);
            base = txn_count;
            phy_write(VECS[i].addr, VECS[i].data);
            chk("R2 mem", {24'd0, mem[VECS[i].addr]}, {24'd0, VECS[i].data});
            chk("R2 last_we", {31'd0, last_we}, 32'd1);
            phy_read(VECS[i].addr, rb);
            chk("R3 last_we", {31'd0, last_we}, 32'd0);
            chk("R6 rbyte", {24'd0, rb}, {24'd0, VECS[i].data});
            chk("R4 count", txn_count - base, 2);
        end

        // R1: fields read back without a strobe, no transaction.
        base = txn_count;
        host_put(word(6'h2A, 8'hC3, 1'b0, 1'b0));
        chk("R1 fields", host_rd_data & 32'h0300_FF3F, 32'h0000_C32A);
        repeat (4) @(negedge clk);
        chk("R1 no txn", txn_count - base, 0);

        // R4/R5: hold write strobe high; one transaction, ack stays set.
        resp_delay = 1;
        base = txn_count;
        host_put(word(6'h05, 8'h77, 1'b0, 1'b0));
        host_put(word(6'h05, 8'h77, 1'b1, 1'b0));
        wait_ack("R5 hold ack");
        repeat (12) @(negedge clk);
        chk("R4 single launch", txn_count - base, 1);
        chk("R5 ack held", {31'd0, host_rd_data[26]}, 32'd1);
        chk("R1 wr strobe bit", {31'd0, host_rd_data[24]}, 32'd1);
        // R5: clear strobe; flag drops exactly one edge later.
        host_put(word(6'h05, 8'h77, 1'b0, 1'b0));
        chk("R5 ack one more cycle", {31'd0, host_rd_data[26]}, 32'd1);
        @(negedge clk);
        chk("R5 ack cleared", {31'd0, host_rd_data[26]}, 32'd0);

        // R6: a later write leaves the read byte (last read 0x3C) alone.
        phy_write(6'h06, 8'h99);
        chk("R6 hold over write", {24'd0, host_rd_data[23:16]}, 32'h3C);

        // R7: both strobes together -> write only.
        base = txn_count;
        host_put(word(6'h0C, 8'h42, 1'b0, 1'b0));
        host_put(word(6'h0C, 8'h42, 1'b1, 1'b1));
        wait_ack("R7 ack");
        repeat (6) @(negedge clk);
        chk("R7 one txn", txn_count - base, 1);
        chk("R7 was write", {31'd0, last_we}, 32'd1);
        chk("R7 mem", {24'd0, mem[12]}, 32'h42);
        chk("R7 rbyte unchanged", {24'd0, host_rd_data[23:16]}, 32'h3C);
        // R7: read edge while write strobe stays set is dropped.
        host_put(word(6'h0C, 8'h42, 1'b1, 1'b0));
        host_put(word(6'h0C, 8'h42, 1'b1, 1'b1));
        repeat (6) @(negedge clk);
        chk("R7 late read dropped", txn_count - base, 1);
        host_put(32'd0);
        @(negedge clk);

        // R8: reserved bits and the ack bit are not writable.
        base = txn_count;
        host_put(32'hFC00_00C0);
        chk("R8 reserved", host_rd_data, 32'h0000_003C & 32'h0 | {8'd0, 8'h3C, 16'd0});
        repeat (4) @(negedge clk);
        chk("R8 no txn", txn_count - base, 0);

        // R9: reset again clears the word.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 word after reset", host_rd_data, 32'd0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule